// File: doc/BRIEF.md
# Reorder Buffer with Precise Faults

This block is the in-order retirement stage of an out-of-order pipeline. Dispatch reserves a slot for each instruction, recording its destination register number and its program counter. Execution units may finish in any order and write the result, or a fault marker, into the slot they were given. Register write-back is released only from the oldest slot, and only once that slot has finished. Results from younger instructions therefore never reach the register file ahead of an older one.

A fault does not interrupt the machine when it happens. It waits in its slot until that slot becomes the oldest. At that point the block raises an exception carrying the slot's program counter and discards every slot, so no younger result ever becomes visible. Decode can probe the buffer with a register number. It receives the newest in-flight value for that register, or learns that the value is still pending. An external flush empties the buffer at once.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: alloc_ready is 1, alloc_idx is 0, and cmt_valid, exc_valid and lk_hit are 0.
- R2: A cycle with alloc_req and alloc_ready high stores the request in slot alloc_idx. Slot numbers are handed out consecutively modulo DEPTH. After DEPTH allocations with no retirement, alloc_ready is 0 and a request is ignored.
- R3: A completion with cmp_valid high writes cmp_data and cmp_fault into slot cmp_idx. A completion aimed at a slot that is not allocated has no effect.
- R4: cmt_valid is high in a cycle exactly when the oldest slot has completed without a fault, with cmt_dst and cmt_data taken from it. At most one slot retires per cycle, in allocation order. A completed younger slot waits behind an unfinished older one.
- R5: When the oldest slot has completed with its fault marker set, exc_valid is 1 and exc_pc carries that slot's program counter, while cmt_valid stays 0.
- R6: The exception cycle discards every slot. In the next cycle the buffer is empty with alloc_idx 0, and no younger slot is ever retired.
- R7: The lookup searches all held slots for lk_reg and reports the youngest match (lk_hit=1). lk_ready is 1 only when that slot completed without a fault, and then lk_data is its result. The lookup reflects completions from earlier cycles.
- R8: With flush high, nothing retires and no exception is raised that cycle. Allocation and completion are ignored, and the buffer is empty with alloc_idx 0 in the next cycle.
- R9: A fault held in a slot that is not the oldest raises no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| alloc_req | input | 1 | Dispatch asks for a slot |
| alloc_dst | input | REG_W | Destination register number of the dispatched instruction |
| alloc_pc | input | PC_W | Program counter of the dispatched instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_idx | output | log2(DEPTH) | Slot number given to this cycle's allocation |
| cmp_valid | input | 1 | An execution unit delivers a result |
| cmp_idx | input | log2(DEPTH) | Slot the result belongs to |
| cmp_data | input | DATA_W | Result value |
| cmp_fault | input | 1 | The instruction faulted |
| flush | input | 1 | Discard every slot |
| cmt_valid | output | 1 | Register write-back from the oldest slot this cycle |
| cmt_dst | output | REG_W | Register written back |
| cmt_data | output | DATA_W | Value written back |
| exc_valid | output | 1 | The oldest slot faulted, raise an exception |
| exc_pc | output | PC_W | Program counter of the faulting instruction |
| lk_reg | input | REG_W | Register number probed by decode |
| lk_hit | output | 1 | Some held slot targets lk_reg |
| lk_ready | output | 1 | The youngest matching slot holds a usable value |
| lk_data | output | DATA_W | Value of the youngest matching slot |

## Verification
alloc_idx, alloc_ready and the lookup outputs are combinational on the current state and the inputs, so each is due in the same cycle as its stimulus. A completion of the oldest slot shows on cmt_valid or exc_valid in the following cycle. Later retirements follow one per cycle, and an exception leaves the buffer empty one cycle after it is raised. The bench changes its inputs on the falling edge and samples 5 ns later. A scoreboard monitor compares each cycle's write-back or exception against the expected queue, in order, so a retirement that comes early, late or out of order is caught.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_RETIRE = 2'd1,
    ACT_TRAP   = 2'd2
  } rob_act_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             clr,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] tail_q, tail_d;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (clr) begin
      head_d = '0;
      tail_d = '0;
    end else begin
      if (push) tail_d = tail_q + PTR_W'(1);
      if (pop)  head_d = head_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  // wrap bit distinguishes a full ring from an empty one
  assign empty = (head_q == tail_q);
  assign full  = (head_q[IDX_W] != tail_q[IDX_W]) &&
                 (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);
endmodule

// File: rtl/rob_commit_ctl.sv
module rob_commit_ctl
  import rob_pkg::*;
(
  input  logic     head_vld,
  input  logic     head_done,
  input  logic     head_flt,
  input  logic     flush,
  output rob_act_e act
);
  always_comb begin
    act = ACT_HOLD;
    if (!flush && head_vld && head_done) begin
      act = head_flt ? ACT_TRAP : ACT_RETIRE;
    end
  end
endmodule

// File: rtl/rob_lookup.sv
module rob_lookup #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [DEPTH-1:0]             vld,
  input  logic [DEPTH-1:0]             done,
  input  logic [DEPTH-1:0]             flt,
  input  logic [DEPTH-1:0][REG_W-1:0]  dst,
  input  logic [DEPTH-1:0][DATA_W-1:0] val,
  input  logic [IDX_W-1:0]             head_idx,
  input  logic [REG_W-1:0]             lk_reg,
  output logic                         lk_hit,
  output logic                         lk_ready,
  output logic [DATA_W-1:0]            lk_data
);
  // walk from oldest to youngest; a later match overrides an earlier one
  always_comb begin
    lk_hit   = 1'b0;
    lk_ready = 1'b0;
    lk_data  = '0;
    for (int k = 0; k < DEPTH; k++) begin : g_scan
      logic [IDX_W-1:0] slot;
      slot = head_idx + IDX_W'(k);
      if (vld[slot] && (dst[slot] == lk_reg)) begin
        lk_hit   = 1'b1;
        lk_ready = done[slot] && !flt[slot];
        lk_data  = val[slot];
      end
    end
  end
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic [REG_W-1:0]  alloc_dst,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              cmp_fault,
  input  logic              flush,
  output logic              cmt_valid,
  output logic [REG_W-1:0]  cmt_dst,
  output logic [DATA_W-1:0] cmt_data,
  output logic              exc_valid,
  output logic [PC_W-1:0]   exc_pc,
  input  logic [REG_W-1:0]  lk_reg,
  output logic              lk_hit,
  output logic              lk_ready,
  output logic [DATA_W-1:0] lk_data
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  // slot state
  logic [DEPTH-1:0]             ent_vld, vld_n;
  logic [DEPTH-1:0]             ent_done, done_n;
  logic [DEPTH-1:0]             ent_flt, flt_n;
  logic [DEPTH-1:0][REG_W-1:0]  ent_dst;
  logic [DEPTH-1:0][PC_W-1:0]   ent_pc;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [DEPTH-1:0]             we_id, we_res;

  logic [IDX_W-1:0] head_idx, tail_idx;
  logic             full, empty;
  rob_act_e         act;
  logic             retire, trap, clr_all, alloc_fire, cmp_fire;

  rob_ptrs #(.IDX_W(IDX_W)) ptrs_i (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .push     (alloc_fire),
    .pop      (retire),
    .clr      (clr_all),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .full     (full),
    .empty    (empty)
  );

  rob_commit_ctl ctl_i (
    .head_vld  (ent_vld[head_idx]),
    .head_done (ent_done[head_idx]),
    .head_flt  (ent_flt[head_idx]),
    .flush     (flush),
    .act       (act)
  );

  assign retire      = (act == ACT_RETIRE);
  assign trap        = (act == ACT_TRAP);
  assign clr_all     = flush || trap;
  assign alloc_ready = !full && !clr_all;
  assign alloc_fire  = alloc_req && alloc_ready;
  assign cmp_fire    = cmp_valid && ent_vld[cmp_idx] && !clr_all;

  always_comb begin
    vld_n  = ent_vld;
    done_n = ent_done;
    flt_n  = ent_flt;
    we_id  = '0;
    we_res = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_fire && (tail_idx == IDX_W'(i))) begin
        vld_n[i]  = 1'b1;
        done_n[i] = 1'b0;
        flt_n[i]  = 1'b0;
        we_id[i]  = 1'b1;
      end
      if (cmp_fire && (cmp_idx == IDX_W'(i))) begin
        done_n[i] = 1'b1;
        flt_n[i]  = cmp_fault;
        we_res[i] = 1'b1;
      end
      if (retire && (head_idx == IDX_W'(i))) vld_n[i] = 1'b0;
      if (clr_all) vld_n[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ent_vld  <= '0;
      ent_done <= '0;
      ent_flt  <= '0;
    end else begin
      ent_vld  <= vld_n;
      ent_done <= done_n;
      ent_flt  <= flt_n;
    end
  end

  // payload registers: clock-enabled, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we_id[i]) begin
        ent_dst[i] <= alloc_dst;
        ent_pc[i]  <= alloc_pc;
      end
      if (we_res[i]) ent_data[i] <= cmp_data;
    end
  end

  rob_lookup #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .REG_W (REG_W),
    .DATA_W(DATA_W)
  ) lookup_i (
    .vld      (ent_vld),
    .done     (ent_done),
    .flt      (ent_flt),
    .dst      (ent_dst),
    .val      (ent_data),
    .head_idx (head_idx),
    .lk_reg   (lk_reg),
    .lk_hit   (lk_hit),
    .lk_ready (lk_ready),
    .lk_data  (lk_data)
  );

  assign alloc_idx = tail_idx;
  assign cmt_valid = retire;
  assign cmt_dst   = ent_dst[head_idx];
  assign cmt_data  = ent_data[head_idx];
  assign exc_valid = trap;
  assign exc_pc    = ent_pc[head_idx];
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk (
  input logic clk,
  input logic rst_n,
  input logic alloc_ready,
  input logic full,
  input logic empty,
  input logic flush,
  input logic cmt_valid,
  input logic exc_valid,
  input logic lk_hit,
  input logic lk_ready
);
  AST_FULL_BLOCKS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_ready); // R2

  AST_EMPTY_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!cmt_valid && !exc_valid)); // R4

  AST_RETIRE_TRAP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmt_valid && exc_valid)); // R5

  AST_TRAP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> empty); // R6

  AST_LOOKUP_READY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ready |-> lk_hit); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R8

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!cmt_valid && !exc_valid)); // R8
endmodule

bind rob_core rob_core_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .alloc_ready (alloc_ready),
  .full        (full),
  .empty       (empty),
  .flush       (flush),
  .cmt_valid   (cmt_valid),
  .exc_valid   (exc_valid),
  .lk_hit      (lk_hit),
  .lk_ready    (lk_ready)
);

// File: tb/rob_core_tb_top.sv
`timescale 1ns/1ps
module rob_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_req = 1'b0;
  logic [4:0]  alloc_dst = '0;
  logic [31:0] alloc_pc = '0;
  logic        alloc_ready;
  logic [2:0]  alloc_idx;
  logic        cmp_valid = 1'b0;
  logic [2:0]  cmp_idx = '0;
  logic [31:0] cmp_data = '0;
  logic        cmp_fault = 1'b0;
  logic        flush = 1'b0;
  logic        cmt_valid;
  logic [4:0]  cmt_dst;
  logic [31:0] cmt_data;
  logic        exc_valid;
  logic [31:0] exc_pc;
  logic [4:0]  lk_reg = '0;
  logic        lk_hit;
  logic        lk_ready;
  logic [31:0] lk_data;

  always #10 clk = ~clk; // 50 MHz

  rob_core dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_dst(alloc_dst), .alloc_pc(alloc_pc),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_data(cmp_data), .cmp_fault(cmp_fault),
    .flush(flush),
    .cmt_valid(cmt_valid), .cmt_dst(cmt_dst), .cmt_data(cmt_data),
    .exc_valid(exc_valid), .exc_pc(exc_pc),
    .lk_reg(lk_reg), .lk_hit(lk_hit), .lk_ready(lk_ready), .lk_data(lk_data)
  );

  typedef struct {
    bit          trap;
    logic [4:0]  dst;
    logic [31:0] val;
  } exp_t;

  exp_t exp_q[$];
  int   nchk = 0;
  int   nerr = 0;
  bit   mon_on = 1'b0;
  bit   done_flag = 1'b0;

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic push_cmt(input logic [4:0] d, input logic [31:0] v);
    exp_t e;
    e.trap = 1'b0; e.dst = d; e.val = v;
    exp_q.push_back(e);
  endtask

  task automatic push_trap(input logic [31:0] pc);
    exp_t e;
    e.trap = 1'b1; e.dst = '0; e.val = pc;
    exp_q.push_back(e);
  endtask

  // monitor: compares every write-back or exception against the queue
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (mon_on && (cmt_valid || exc_valid)) begin
        if (exp_q.size() == 0) begin
          check_eq("R4", "unexpected retirement (valid)", 32'(cmt_valid), 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.trap) begin
            check_eq("R5", "exc_valid", 32'(exc_valid), 32'h1);
            check_eq("R5", "exc_pc", exc_pc, e.val);
          end else begin
            check_eq("R4", "cmt_valid", 32'(cmt_valid), 32'h1);
            check_eq("R4", "cmt_dst", 32'(cmt_dst), 32'(e.dst));
            check_eq("R4", "cmt_data", cmt_data, e.val);
          end
        end
      end
    end
  end

  task automatic alloc(input logic [4:0] d, input logic [31:0] pc,
                       input logic [2:0] expi, input string req);
    @(negedge clk);
    alloc_req = 1'b1; alloc_dst = d; alloc_pc = pc;
    #5;
    check_eq(req, "alloc_ready", 32'(alloc_ready), 32'h1);
    check_eq(req, "alloc_idx", 32'(alloc_idx), 32'(expi));
    @(posedge clk);
    #1 alloc_req = 1'b0;
  endtask

  task automatic complete(input logic [2:0] idx, input logic [31:0] v, input bit f);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_idx = idx; cmp_data = v; cmp_fault = f;
    @(posedge clk);
    #1 cmp_valid = 1'b0; cmp_fault = 1'b0;
  endtask

  task automatic probe(input logic [4:0] r, input bit eh, input bit er,
                       input logic [31:0] ed, input string req);
    @(negedge clk);
    lk_reg = r;
    #5;
    check_eq(req, "lk_hit", 32'(lk_hit), 32'(eh));
    check_eq(req, "lk_ready", 32'(lk_ready), 32'(er));
    if (er) check_eq(req, "lk_data", lk_data, ed);
  endtask

  task automatic quiet(input string req);
    @(negedge clk);
    #5;
    check_eq(req, "cmt_valid idle", 32'(cmt_valid), 32'h0);
    check_eq(req, "exc_valid idle", 32'(exc_valid), 32'h0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      nerr++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(4);

    // R1 reset state
    @(negedge clk);
    #5;
    check_eq("R1", "alloc_ready", 32'(alloc_ready), 32'h1);
    check_eq("R1", "alloc_idx", 32'(alloc_idx), 32'h0);
    check_eq("R1", "cmt_valid", 32'(cmt_valid), 32'h0);
    check_eq("R1", "exc_valid", 32'(exc_valid), 32'h0);
    check_eq("R1", "lk_hit", 32'(lk_hit), 32'h0);
    mon_on = 1'b1;

    // out-of-order completion, in-order retirement, youngest bypass
    alloc(5'd3, 32'h100, 3'd0, "R2");
    alloc(5'd4, 32'h104, 3'd1, "R2");
    alloc(5'd3, 32'h108, 3'd2, "R2");
    probe(5'd3, 1'b1, 1'b0, 32'h0, "R7 youngest pending");
    complete(3'd2, 32'h33, 1'b0);
    probe(5'd3, 1'b1, 1'b1, 32'h33, "R7 youngest ready");
    complete(3'd1, 32'h22, 1'b0);
    quiet("R4 younger waits");
    probe(5'd4, 1'b1, 1'b1, 32'h22, "R3 result stored");
    push_cmt(5'd3, 32'h11);
    push_cmt(5'd4, 32'h22);
    push_cmt(5'd3, 32'h33);
    complete(3'd0, 32'h11, 1'b0);
    idle(5);
    probe(5'd3, 1'b0, 1'b0, 32'h0, "R7 drained");

    // completion to an unallocated slot is ignored
    complete(3'd5, 32'h55, 1'b0);
    quiet("R3 stray completion");
    check_eq("R3", "alloc_idx after stray", 32'(alloc_idx), 32'h3);

    // fill to capacity, then an ignored request
    for (int k = 0; k < 8; k++) alloc(5'(k + 1), 32'h300 + 32'(4 * k), 3'((3 + k) % 8), "R2 fill");
    @(negedge clk);
    alloc_req = 1'b1; alloc_dst = 5'd31; alloc_pc = 32'h3ff;
    #5 check_eq("R2", "alloc_ready full", 32'(alloc_ready), 32'h0);
    @(posedge clk);
    #1 alloc_req = 1'b0;
    probe(5'd31, 1'b0, 1'b0, 32'h0, "R2 request ignored when full");
    probe(5'd5, 1'b1, 1'b0, 32'h0, "R7 pending slot");
    for (int k = 0; k < 8; k++) push_cmt(5'(k + 1), 32'h1000 + 32'(k));
    for (int k = 7; k >= 0; k--) complete(3'((3 + k) % 8), 32'h1000 + 32'(k), 1'b0);
    idle(12);
    check_eq("R2", "alloc_idx wrapped", 32'(alloc_idx), 32'h3);

    // fault held until its slot is oldest
    alloc(5'd10, 32'h200, 3'd3, "R2");
    alloc(5'd11, 32'h204, 3'd4, "R2");
    alloc(5'd12, 32'h208, 3'd5, "R2");
    complete(3'd4, 32'h0, 1'b1);
    quiet("R9 younger fault silent");
    probe(5'd11, 1'b1, 1'b0, 32'h0, "R7 faulted slot not ready");
    complete(3'd5, 32'hC0, 1'b0);
    push_cmt(5'd10, 32'hA0);
    push_trap(32'h204);
    complete(3'd3, 32'hA0, 1'b0);
    idle(5);
    check_eq("R6", "alloc_idx after trap", 32'(alloc_idx), 32'h0);
    probe(5'd12, 1'b0, 1'b0, 32'h0, "R6 younger discarded");

    // flush with a same-cycle completion
    alloc(5'd20, 32'h400, 3'd0, "R2");
    alloc(5'd21, 32'h404, 3'd1, "R2");
    complete(3'd1, 32'h21, 1'b0);
    @(negedge clk);
    flush = 1'b1; cmp_valid = 1'b1; cmp_idx = 3'd0; cmp_data = 32'h20;
    alloc_req = 1'b1; alloc_dst = 5'd23; alloc_pc = 32'h40c;
    #5;
    check_eq("R8", "alloc_ready during flush", 32'(alloc_ready), 32'h0);
    check_eq("R8", "cmt_valid during flush", 32'(cmt_valid), 32'h0);
    @(posedge clk);
    #1 flush = 1'b0; cmp_valid = 1'b0; alloc_req = 1'b0;
    idle(3);
    probe(5'd21, 1'b0, 1'b0, 32'h0, "R8 flushed");
    probe(5'd23, 1'b0, 1'b0, 32'h0, "R8 alloc ignored");
    check_eq("R8", "alloc_idx after flush", 32'(alloc_idx), 32'h0);
    alloc(5'd22, 32'h408, 3'd0, "R8 reuse");
    push_cmt(5'd22, 32'h2222);
    complete(3'd0, 32'h2222, 1'b0);
    idle(4);

    check_eq("R4", "pending expectations", 32'(exp_q.size()), 32'h0);
    done_flag = 1'b1;
    summary();
    $finish;
  end
endmodule